// File: doc/BRIEF.md
# Boot Host-Interface Auto-Selector

This block sits in front of a boot loader and decides, after reset, which of four host links the loader will talk over: two serial UART ports (A and B), a CAN port and a USB device port. The receivers and the USB core live elsewhere. This block sees only one activity flag from each of them: a sync-byte-seen flag from each UART, a frame-activity flag from CAN, and a cable-present flag from USB. It also sees the raw external reference clock.

The selector visits the four flags in a fixed rotation, one per clock cycle. It commits to the first source whose flag is high when that source's turn comes. A UART is taken at once. CAN and USB first need the external clock to be measured. The selector counts external-clock edges over a fixed window of internal cycles. The count must lie within a tolerance band around one of three expected counts, which correspond to 8 MHz, 14.7456 MHz and 25 MHz. If the measurement passes, the interface is selected; USB also raises a request to move the system clock to 48 MHz. If it fails, the selector emits a one-cycle system-reset request and halts. Once it has committed, in either direction, nothing on the inputs changes its outputs until the next reset.

The select output is one-hot and doubles as the enable for each interface. Every bit that is not set keeps that interface disabled.

Top module: `bootsel_detector`

## Requirements
- R1: While reset is asserted (and in the cycle after it), `sel` is 0000 and `sel_valid`, `sys_reset_req` and `hs_clk_req` are all low.
- R2: After reset the selector examines one source per clock, in the repeating order UART A, UART B, CAN, USB, starting with UART A on the first clock edge after reset is released. It acts only on the source whose turn it is.
- R3: A high UART flag, seen on its turn, drives `sel` and `sel_valid` from the very next output cycle. UART A gives `sel`=0001 and UART B gives `sel`=0010.
- R4: A high CAN or USB flag, seen on its turn, starts a measurement of the external clock over WIN_CYC internal cycles. The outcome appears at the outputs WIN_CYC+1 clock edges after the edge that saw the flag.
- R5: If the rising-edge count lies within TOL of any of the three expected counts, the candidate is selected. CAN gives `sel`=0100 and USB gives `sel`=1000.
- R6: If the count is outside every band (including no external clock at all), `sys_reset_req` is high for exactly one cycle. No interface is selected, and later activity on any input has no effect until reset.
- R7: Selecting USB raises `hs_clk_req` together with `sel_valid` and holds it. It stays low for every other outcome.
- R8: Once `sel_valid` is high, `sel` and `sel_valid` hold their values until reset, whatever the activity flags do afterwards, including a USB cable being attached.
- R9: Activity on any source while a measurement is in progress is ignored. The measured candidate alone decides the outcome.
- R10: Whenever `sel_valid` is high, exactly one bit of `sel` is set; whenever it is low, `sel` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uart_a_sync | input | 1 | UART A has received the sync byte |
| uart_b_sync | input | 1 | UART B has received the sync byte |
| can_active | input | 1 | Frame activity seen on the CAN receive line |
| usb_present | input | 1 | USB cable detected |
| ext_clk | input | 1 | Raw external reference clock (asynchronous) |
| sel | output | 4 | One-hot interface select / enable: bit0 UART A, bit1 UART B, bit2 CAN, bit3 USB |
| sel_valid | output | 1 | A selection has been made |
| sys_reset_req | output | 1 | One-cycle system-reset request after a failed clock check |
| hs_clk_req | output | 1 | Request to move the system clock to 48 MHz (USB chosen) |

## Verification
The bench builds the selector with a 240-cycle window, expected counts of 24, 40 and 60, and a tolerance of 2. A bench-generated external clock with a period of 10, 6 or 4 internal cycles therefore passes, while a period of 8 (count 30) or a stopped clock fails. This keeps each measurement short enough that CAN and USB passes, failures and activity during the window can all be covered in a single run. Flags are raised at chosen offsets from reset so that the rotation position decides between simultaneous sources.

// File: rtl/bootsel_pkg.sv
// Shared types for the boot interface selector.
package bootsel_pkg;
    localparam int NSRC = 4;

    // Source index; the numeric value is also the bit position in the select.
    typedef enum logic [1:0] {
        SRC_UART_A = 2'd0,
        SRC_UART_B = 2'd1,
        SRC_CAN    = 2'd2,
        SRC_USB    = 2'd3
    } src_e;

    // Selector phases.
    typedef enum logic [1:0] {
        ST_POLL = 2'd0,
        ST_MEAS = 2'd1,
        ST_LOCK = 2'd2,
        ST_HALT = 2'd3
    } phase_e;
endpackage

// File: rtl/bootsel_clk_meter.sv
// Counts rising edges of an asynchronous clock over a window of WIN_CYC
// internal cycles. A start pulse begins the window; done pulses for one
// cycle with the final count on the cycle after the window's last cycle.
// Assumes the measured clock is slower than half the internal clock.
module bootsel_clk_meter #(
    parameter int unsigned WIN_CYC = 1000,
    parameter int unsigned CW      = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_clk,
    input  logic          start,
    output logic          done,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

    logic [2:0]    sync_q;
    logic          rise;
    logic          busy;
    logic [CW-1:0] cyc;
    logic [CW-1:0] acc;

    // Bring the external clock into the internal domain, keep one extra stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ext_clk};
    end

    assign rise = sync_q[1] & ~sync_q[2];

    // Run the window: count internal cycles and external rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cyc   <= '0;
            acc   <= '0;
            done  <= 1'b0;
            count <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cyc  <= '0;
                acc  <= '0;
            end else if (busy) begin
                cyc <= cyc + 1'b1;
                if (cyc == LAST) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    count <= acc + CW'(rise);
                end else begin
                    acc <= acc + CW'(rise);
                end
            end
        end
    end
endmodule

// File: rtl/bootsel_band_check.sv
// Decides whether a measured edge count falls within +/-TOL of any of the
// NREF expected counts. Purely combinational; assumes CW < 32.
module bootsel_band_check #(
    parameter int unsigned CW          = 10,
    parameter int unsigned NREF        = 3,
    parameter int unsigned REFS [NREF] = '{default: 0},
    parameter int unsigned TOL         = 3
) (
    input  logic [CW-1:0] cnt,
    output logic          in_band
);
    logic [31:0]     cnt_w;
    logic [NREF-1:0] hit;

    assign cnt_w = {{(32 - CW){1'b0}}, cnt};

    // One window comparator per expected count.
    for (genvar i = 0; i < NREF; i++) begin : g_band
        assign hit[i] = ((cnt_w + TOL) >= REFS[i]) && (cnt_w <= (REFS[i] + TOL));
    end

    assign in_band = |hit;
endmodule

// File: rtl/bootsel_detector.sv
// Boot host-interface auto-selector. Rotates through four activity flags,
// one per cycle, and commits to the first one found high on its turn.
// UARTs are taken at once; CAN and USB are taken only after the external
// clock passes a frequency check, otherwise a one-cycle reset request is
// issued and the block halts. Commitment lasts until the next reset.
// Assumes the activity flags are already synchronous to clk.
module bootsel_detector #(
    parameter int unsigned WIN_CYC = 1000,
    parameter int unsigned REF_A   = 80,
    parameter int unsigned REF_B   = 147,
    parameter int unsigned REF_C   = 250,
    parameter int unsigned TOL     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uart_a_sync,
    input  logic       uart_b_sync,
    input  logic       can_active,
    input  logic       usb_present,
    input  logic       ext_clk,
    output logic [3:0] sel,
    output logic       sel_valid,
    output logic       sys_reset_req,
    output logic       hs_clk_req
);
    import bootsel_pkg::*;

    localparam int unsigned CW = $clog2(WIN_CYC + 1);

    phase_e          phase;
    src_e            turn;
    src_e            cand;
    logic [NSRC-1:0] src;
    logic            turn_hit;
    logic            needs_check;
    logic            meas_start;
    logic            meas_done;
    logic [CW-1:0]   meas_cnt;
    logic            clk_ok;

    assign src         = {usb_present, can_active, uart_b_sync, uart_a_sync};
    assign turn_hit    = src[turn];
    assign needs_check = (turn == SRC_CAN) || (turn == SRC_USB);
    assign meas_start  = (phase == ST_POLL) && turn_hit && needs_check;

    bootsel_clk_meter #(
        .WIN_CYC (WIN_CYC),
        .CW      (CW)
    ) i_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_clk (ext_clk),
        .start   (meas_start),
        .done    (meas_done),
        .count   (meas_cnt)
    );

    bootsel_band_check #(
        .CW   (CW),
        .NREF (3),
        .REFS ('{REF_A, REF_B, REF_C}),
        .TOL  (TOL)
    ) i_band (
        .cnt     (meas_cnt),
        .in_band (clk_ok)
    );

    // Poll, measure, and commit; all outputs are registered here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase         <= ST_POLL;
            turn          <= SRC_UART_A;
            cand          <= SRC_UART_A;
            sel           <= '0;
            sel_valid     <= 1'b0;
            sys_reset_req <= 1'b0;
            hs_clk_req    <= 1'b0;
        end else begin
            case (phase)
                ST_POLL: begin
                    turn <= src_e'(turn + 2'd1);
                    if (turn_hit) begin
                        if (needs_check) begin
                            cand  <= turn;
                            phase <= ST_MEAS;
                        end else begin
                            sel       <= NSRC'(1) << turn;
                            sel_valid <= 1'b1;
                            phase     <= ST_LOCK;
                        end
                    end
                end
                ST_MEAS: begin
                    if (meas_done) begin
                        if (clk_ok) begin
                            sel        <= NSRC'(1) << cand;
                            sel_valid  <= 1'b1;
                            hs_clk_req <= (cand == SRC_USB);
                            phase      <= ST_LOCK;
                        end else begin
                            sys_reset_req <= 1'b1;
                            phase         <= ST_HALT;
                        end
                    end
                end
                ST_HALT: begin
                    sys_reset_req <= 1'b0;
                end
                default: begin
                    // ST_LOCK: hold the selection until reset.
                end
            endcase
        end
    end
endmodule

// File: rtl/bootsel_checker.sv
// Temporal checks on the selector's outputs, bound to every instance.
module bootsel_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] sel,
    input logic       sel_valid,
    input logic       sys_reset_req,
    input logic       hs_clk_req
);
    // R10: one-hot select while valid
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> ($countones(sel) == 1));

    // R10: empty select while not valid
    a_r10_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (sel == 4'b0000));

    // R8: a committed selection never moves
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> (sel_valid && $stable(sel)));

    // R6: reset request lasts one cycle and is never followed by a selection
    a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> (!sys_reset_req && !sel_valid));

    // R6: no selection alongside a reset request
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> !sel_valid);

    // R7: clock-switch request only with USB selected
    a_r7_usb_only: assert property (@(posedge clk) disable iff (!rst_n)
        hs_clk_req |-> (sel_valid && sel[3]));

    // R7: request is held once raised
    a_r7_held: assert property (@(posedge clk) disable iff (!rst_n)
        hs_clk_req |=> hs_clk_req);
endmodule

bind bootsel_detector bootsel_checker i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel           (sel),
    .sel_valid     (sel_valid),
    .sys_reset_req (sys_reset_req),
    .hs_clk_req    (hs_clk_req)
);

// File: tb/test_bootsel_detector.sv
module test_bootsel_detector;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 240;
    localparam int RA = 24, RB = 40, RC = 60, TL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uart_a_sync = 1'b0, uart_b_sync = 1'b0, can_active = 1'b0, usb_present = 1'b0;
    logic       ext_clk = 1'b0;
    logic [3:0] sel;
    logic       sel_valid, sys_reset_req, hs_clk_req;

    int    ext_half = 0;   // external clock half period in internal cycles, 0 = stopped
    int    errors = 0, checks = 0, rst_pulses = 0;
    string cur_req = "R1";

    bootsel_detector #(.WIN_CYC(WIN), .REF_A(RA), .REF_B(RB), .REF_C(RC), .TOL(TL)) i_bootsel_detector (
        .clk(clk), .rst_n(rst_n), .uart_a_sync(uart_a_sync), .uart_b_sync(uart_b_sync),
        .can_active(can_active), .usb_present(usb_present), .ext_clk(ext_clk),
        .sel(sel), .sel_valid(sel_valid), .sys_reset_req(sys_reset_req), .hs_clk_req(hs_clk_req));

    always #(CLK_PERIOD / 2) clk = ~clk;

    // External reference clock, period chosen by the scenario.
    initial begin
        forever begin
            if (ext_half == 0) @(negedge clk);
            else begin
                repeat (ext_half) @(negedge clk);
                ext_clk = ~ext_clk;
            end
        end
    end

    // Behavioural reference: rotation, window timer, commitment.
    int         m_phase = 0, m_turn = 0, m_cand = 0, m_tmr = 0;
    logic [3:0] e_sel = '0;
    bit         e_val = 0, e_rst = 0, e_hs = 0;

    function automatic bit ref_clock_ok();
        int n;
        int refs[3];
        refs = '{RA, RB, RC};
        if (ext_half == 0) return 0;
        n = WIN / (2 * ext_half);
        foreach (refs[i]) if (n >= refs[i] - TL && n <= refs[i] + TL) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit flags[4];
        flags = '{uart_a_sync, uart_b_sync, can_active, usb_present};
        if (!rst_n) begin
            m_phase = 0; m_turn = 0; e_sel = '0; e_val = 0; e_rst = 0; e_hs = 0;
        end else begin
            case (m_phase)
                0: begin
                    if (flags[m_turn]) begin
                        if (m_turn < 2) begin e_sel = 4'(1 << m_turn); e_val = 1; m_phase = 2; end
                        else begin m_cand = m_turn; m_tmr = 0; m_phase = 1; end
                    end
                    m_turn = (m_turn + 1) % 4;
                end
                1: begin
                    m_tmr++;
                    if (m_tmr == WIN + 1) begin
                        if (ref_clock_ok()) begin
                            e_sel = 4'(1 << m_cand); e_val = 1; e_hs = (m_cand == 3); m_phase = 2;
                        end else begin
                            e_rst = 1; m_phase = 3;
                        end
                    end
                end
                3: e_rst = 0;
                default: ;
            endcase
        end
    end

    task automatic check4(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare against the reference on every clock, away from the edge.
    always @(negedge clk) begin
        if (sys_reset_req === 1'b1) rst_pulses++;
        check4(cur_req, "sel", sel, e_sel);
        check4(cur_req, "sel_valid", {3'b0, sel_valid}, {3'b0, e_val});
        check4(cur_req, "sys_reset_req", {3'b0, sys_reset_req}, {3'b0, e_rst});
        check4(cur_req, "hs_clk_req", {3'b0, hs_clk_req}, {3'b0, e_hs});
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        uart_a_sync = 0; uart_b_sync = 0; can_active = 0; usb_present = 0;
        repeat (3) @(negedge clk);
        rst_pulses = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        do_reset();
        check4("R1", "sel after reset", sel, 4'b0000);
        check4("R1", "flags after reset", {1'b0, sel_valid, sys_reset_req, hs_clk_req}, 4'b0000);

        // R3: UART A
        cur_req = "R3";
        do_reset();
        uart_a_sync = 1; wait_cyc(6); uart_a_sync = 0; wait_cyc(4);
        check4("R3", "uart A select", sel, 4'b0001);

        // R3: UART B
        do_reset();
        uart_b_sync = 1; wait_cyc(6); uart_b_sync = 0; wait_cyc(4);
        check4("R3", "uart B select", sel, 4'b0010);

        // R2: B and CAN together right after reset; B's turn comes first
        cur_req = "R2";
        do_reset();
        ext_half = 3;
        uart_b_sync = 1; can_active = 1; wait_cyc(6);
        uart_b_sync = 0; can_active = 0; wait_cyc(4);
        check4("R2", "B before CAN", sel, 4'b0010);

        // R2: all four raised at release; A is looked at first
        do_reset();
        uart_a_sync = 1; uart_b_sync = 1; can_active = 1; usb_present = 1; wait_cyc(6);
        uart_a_sync = 0; uart_b_sync = 0; can_active = 0; usb_present = 0; wait_cyc(4);
        check4("R2", "A first", sel, 4'b0001);

        // R4/R5: CAN with a 6-cycle external clock (count 40)
        cur_req = "R5";
        do_reset();
        ext_half = 3;
        can_active = 1; wait_cyc(6); can_active = 0;
        wait_cyc(WIN - 10);
        check4("R4", "no decision mid-window", {3'b0, sel_valid}, 4'b0000);
        wait_cyc(20);
        check4("R5", "CAN select", sel, 4'b0100);
        check4("R7", "no clock request for CAN", {3'b0, hs_clk_req}, 4'b0000);

        // R7: USB with a 4-cycle external clock (count 60)
        cur_req = "R7";
        do_reset();
        ext_half = 2;
        usb_present = 1; wait_cyc(WIN + 10);
        check4("R5", "USB select", sel, 4'b1000);
        check4("R7", "clock request for USB", {3'b0, hs_clk_req}, 4'b0001);

        // R6: CAN with an 8-cycle clock (count 30) fails, then input is dead
        cur_req = "R6";
        do_reset();
        ext_half = 4;
        can_active = 1; wait_cyc(6); can_active = 0;
        wait_cyc(WIN + 10);
        check4("R6", "reset pulses", 4'(rst_pulses), 4'd1);
        ext_half = 2;
        uart_a_sync = 1; usb_present = 1; wait_cyc(WIN + 20);
        uart_a_sync = 0; usb_present = 0;
        check4("R6", "halted select", {sel_valid, sel[2:0]}, 4'b0000);
        check4("R6", "no further pulses", 4'(rst_pulses), 4'd1);

        // R6: USB with no external clock
        do_reset();
        ext_half = 0;
        usb_present = 1; wait_cyc(WIN + 10); usb_present = 0;
        check4("R6", "usb no clock pulse", 4'(rst_pulses), 4'd1);
        check4("R6", "usb no clock select", sel, 4'b0000);

        // R8: lock on A, then everything else becomes active
        cur_req = "R8";
        do_reset();
        ext_half = 2;
        uart_a_sync = 1; wait_cyc(3); uart_a_sync = 0;
        uart_b_sync = 1; can_active = 1; usb_present = 1; wait_cyc(WIN + 20);
        check4("R8", "A kept", sel, 4'b0001);
        check4("R8", "no clock request", {3'b0, hs_clk_req}, 4'b0000);
        uart_b_sync = 0; can_active = 0; usb_present = 0;

        // R9: UART activity during a CAN measurement (10-cycle clock, count 24)
        cur_req = "R9";
        do_reset();
        ext_half = 5;
        wait_cyc(2);
        can_active = 1; wait_cyc(2); can_active = 0;
        wait_cyc(5);
        uart_a_sync = 1; uart_b_sync = 1; usb_present = 1; wait_cyc(WIN);
        uart_a_sync = 0; uart_b_sync = 0; usb_present = 0;
        wait_cyc(5);
        check4("R9", "CAN kept over UART", sel, 4'b0100);
        check4("R10", "single bit", 4'($countones(sel)), 4'd1);

        wait_cyc(4);
        summary();
    end
endmodule